// File: doc/BRIEF.md
# Integer Adder with Condition Flags

This block is the add path of a load/store processor's integer unit. Each accepted operation adds two operands and a carry-in term. The first operand is a register value, or the constant zero when the base register index is zero. The second operand is a register value or an immediate. The carry-in is either zero or the carry bit left by an earlier operation.

Alongside the sum, the block keeps three status bits: carry, overflow and a sticky summary overflow. It also keeps a four-bit condition field. Per-operation controls decide which of these are written:

- a carry-compute enable for the carry bit;
- an overflow enable for the overflow and summary bits;
- a record bit for the condition field.

The overflow enable and the record bit are independent, so all four combinations are valid. Results and flags are registered on one clock edge and marked by a one-cycle valid strobe.

Top module: `sum_flag_unit`

## Requirements
- R1: One clock edge after `op_valid` is sampled high, `result` holds (A + B + cin) modulo 2^DATA_W. B is `imm` when `use_imm` is 1, and `reg_b` otherwise.
- R2: With `cin_sel` = 0 the carry-in is 0. With `cin_sel` = 1 the carry-in is the value `flag_ca` held before the operation.
- R3: With `a_zero` = 1, operand A is the constant 0 whatever `reg_a` holds. With `a_zero` = 0, operand A is `reg_a`.
- R4: An operation with `ca_en` = 1 writes `flag_ca` with the carry out of bit DATA_W-1. With `ca_en` = 0, `flag_ca` keeps its value.
- R5: An operation with `oe_en` = 1 that has signed overflow sets both `flag_ov` and `flag_so` to 1. Signed overflow means A and B have the same sign bit and the result's sign bit differs from it; the carry-in is part of the sum.
- R6: An operation with `oe_en` = 1 and no signed overflow clears `flag_ov` and leaves `flag_so` unchanged. With `oe_en` = 0, both bits keep their values. `flag_so` never falls except on reset.
- R7: An operation with `rc_en` = 1 writes `cond` as {LT, GT, EQ, SO}, with bit 3 = LT, bit 2 = GT, bit 1 = EQ and bit 0 = SO. LT, GT and EQ compare the signed result with zero, and exactly one of them is 1. With `rc_en` = 0, `cond` keeps its value.
- R8: The SO bit of `cond` is the value `flag_so` takes after the same operation. This includes the case where that operation's overflow has just set it.
- R9: `res_valid` is high for exactly the cycles that follow a cycle with `op_valid` high. When `op_valid` is low, `result`, the flags and `cond` hold.
- R10: A synchronous reset (`rst` = 1 at a clock edge) clears `flag_ca`, `flag_ov`, `flag_so`, `cond`, `result` and `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present this cycle |
| reg_a | input | DATA_W | Base register operand |
| reg_b | input | DATA_W | Second register operand |
| imm | input | DATA_W | Immediate operand |
| use_imm | input | 1 | Select `imm` as operand B |
| a_zero | input | 1 | Base register index is zero: operand A = 0 |
| cin_sel | input | 1 | Carry-in source: 0 = zero, 1 = stored carry |
| ca_en | input | 1 | Write carry bit with carry out |
| oe_en | input | 1 | Update overflow and summary overflow |
| rc_en | input | 1 | Record condition field |
| res_valid | output | 1 | Result registered from previous cycle |
| result | output | DATA_W | Registered sum |
| flag_ca | output | 1 | Carry bit |
| flag_ov | output | 1 | Overflow bit |
| flag_so | output | 1 | Sticky summary overflow bit |
| cond | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The hardest situation to reach is a run of dependent operations. In such a run the stored carry feeds the next sum. A sticky summary bit set long ago must survive an overflow-enabled operation that clears the overflow bit. A record operation must pick up a summary bit that the same operation has just raised.

The stimulus sweeps every operand pair of a 4-bit instance. Within each pair it runs all 64 control combinations back to back, so each operation inherits the carry and summary state of the one before. A reference model in the bench tracks that chained state. Mid-sweep resets and idle cycles break the chain on purpose, to show that the state restarts or holds.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
   // Condition field layout: bit 3 LT, bit 2 GT, bit 1 EQ, bit 0 SO
   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } cond_t;

   localparam int COND_W = $bits(cond_t);
endpackage

// File: rtl/sfu_opsel.sv
module sfu_opsel #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] reg_a,
   input  logic [DATA_W-1:0] reg_b,
   input  logic [DATA_W-1:0] imm,
   input  logic              use_imm,
   input  logic              a_zero,
   output logic [DATA_W-1:0] op_a,
   output logic [DATA_W-1:0] op_b
);
   always_comb begin
      op_a = a_zero  ? '0  : reg_a;
      op_b = use_imm ? imm : reg_b;
   end
endmodule

// File: rtl/sfu_adder.sv
module sfu_adder #(
   parameter int DATA_W      = 32,
   parameter int ADDER_STYLE = 0   // 0: operator add, 1: explicit ripple chain
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              ovf
);
   localparam int MSB = DATA_W - 1;

   generate
      if (ADDER_STYLE == 0) begin : g_behav
         logic [DATA_W:0] wide;
         always_comb begin
            wide = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, cin};
         end
         assign sum  = wide[MSB:0];
         assign cout = wide[DATA_W];
      end else begin : g_ripple
         logic [DATA_W:0] c;
         assign c[0] = cin;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]  = op_a[i] ^ op_b[i] ^ c[i];
            assign c[i+1]  = (op_a[i] & op_b[i]) | (c[i] & (op_a[i] ^ op_b[i]));
         end
         assign cout = c[DATA_W];
      end
   endgenerate

   // Same-sign operands whose sum changes sign
   assign ovf = (op_a[MSB] == op_b[MSB]) && (sum[MSB] != op_a[MSB]);
endmodule

// File: rtl/sfu_flags.sv
module sfu_flags (
   input  logic clk,
   input  logic rst,
   input  logic upd,
   input  logic ca_en,
   input  logic oe_en,
   input  logic cout,
   input  logic ovf,
   output logic ca_q,
   output logic ov_q,
   output logic so_q,
   output logic so_next
);
   logic ca_d, ov_d;

   always_comb begin
      ca_d    = ca_q;
      ov_d    = ov_q;
      so_next = so_q;
      if (upd && ca_en) ca_d = cout;
      if (upd && oe_en) begin
         ov_d    = ovf;
         so_next = so_q | ovf;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ca_q <= 1'b0;
         ov_q <= 1'b0;
         so_q <= 1'b0;
      end else begin
         ca_q <= ca_d;
         ov_q <= ov_d;
         so_q <= so_next;
      end
   end
endmodule

// File: rtl/sfu_cond.sv
module sfu_cond
   import sfu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] value,
   input  logic              so_in,
   output cond_t             cond
);
   logic is_zero, is_neg;

   always_comb begin
      is_zero = (value == '0);
      is_neg  = value[DATA_W-1];
      cond.lt = is_neg;
      cond.gt = !is_neg && !is_zero;
      cond.eq = is_zero;
      cond.so = so_in;
   end
endmodule

// File: rtl/sum_flag_unit.sv
module sum_flag_unit
   import sfu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDER_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_valid,
   input  logic [DATA_W-1:0] reg_a,
   input  logic [DATA_W-1:0] reg_b,
   input  logic [DATA_W-1:0] imm,
   input  logic              use_imm,
   input  logic              a_zero,
   input  logic              cin_sel,
   input  logic              ca_en,
   input  logic              oe_en,
   input  logic              rc_en,
   output logic              res_valid,
   output logic [DATA_W-1:0] result,
   output logic              flag_ca,
   output logic              flag_ov,
   output logic              flag_so,
   output logic [COND_W-1:0] cond
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("sum_flag_unit: DATA_W must be at least 2");
      end
      if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
         $error("sum_flag_unit: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   logic [DATA_W-1:0] op_a, op_b, sum;
   logic              cin, cout, ovf, so_next;
   cond_t             cond_d;

   sfu_opsel #(.DATA_W(DATA_W)) u_opsel (
      .reg_a   (reg_a),
      .reg_b   (reg_b),
      .imm     (imm),
      .use_imm (use_imm),
      .a_zero  (a_zero),
      .op_a    (op_a),
      .op_b    (op_b)
   );

   assign cin = cin_sel & flag_ca;

   sfu_adder #(.DATA_W(DATA_W), .ADDER_STYLE(ADDER_STYLE)) u_adder (
      .op_a (op_a),
      .op_b (op_b),
      .cin  (cin),
      .sum  (sum),
      .cout (cout),
      .ovf  (ovf)
   );

   sfu_flags u_flags (
      .clk     (clk),
      .rst     (rst),
      .upd     (op_valid),
      .ca_en   (ca_en),
      .oe_en   (oe_en),
      .cout    (cout),
      .ovf     (ovf),
      .ca_q    (flag_ca),
      .ov_q    (flag_ov),
      .so_q    (flag_so),
      .so_next (so_next)
   );

   sfu_cond #(.DATA_W(DATA_W)) u_cond (
      .value (sum),
      .so_in (so_next),
      .cond  (cond_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid <= 1'b0;
         result    <= '0;
         cond      <= '0;
      end else begin
         res_valid <= op_valid;
         if (op_valid) result <= sum;
         if (op_valid && rc_en) cond <= cond_d;
      end
   end
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              op_valid,
   input logic              ca_en,
   input logic              oe_en,
   input logic              rc_en,
   input logic              res_valid,
   input logic [DATA_W-1:0] result,
   input logic              flag_ca,
   input logic              flag_ov,
   input logic              flag_so,
   input logic [3:0]        cond
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) op_valid |=> res_valid); // R9
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !op_valid |=> !res_valid); // R9
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !op_valid |=> $stable(result)); // R9
   AST_CA_HOLD: assert property (@(posedge clk) disable iff (rst) (!op_valid || !ca_en) |=> $stable(flag_ca)); // R4
   AST_OV_HOLD: assert property (@(posedge clk) disable iff (rst) (!op_valid || !oe_en) |=> $stable(flag_ov)); // R6
   AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst) flag_so |=> flag_so); // R6
   AST_OV_IMPLIES_SO: assert property (@(posedge clk) disable iff (rst) flag_ov |-> flag_so); // R5
   AST_COND_ONEHOT: assert property (@(posedge clk) disable iff (rst) (op_valid && rc_en) |=> $countones(cond[3:1]) == 1); // R7
   AST_COND_EQ_ZERO: assert property (@(posedge clk) disable iff (rst) (op_valid && rc_en) |=> cond[1] == (result == '0)); // R7
   AST_COND_HOLD: assert property (@(posedge clk) disable iff (rst) !(op_valid && rc_en) |=> $stable(cond)); // R7
   AST_COND_SO: assert property (@(posedge clk) disable iff (rst) (op_valid && rc_en) |=> cond[0] == flag_so); // R8
endmodule

bind sum_flag_unit sfu_checker #(.DATA_W(DATA_W)) u_sfu_checker (
   .clk       (clk),
   .rst       (rst),
   .op_valid  (op_valid),
   .ca_en     (ca_en),
   .oe_en     (oe_en),
   .rc_en     (rc_en),
   .res_valid (res_valid),
   .result    (result),
   .flag_ca   (flag_ca),
   .flag_ov   (flag_ov),
   .flag_so   (flag_so),
   .cond      (cond)
);

// File: tb/test_sum_flag_unit.sv
module test_sum_flag_unit;
   localparam int W = 4;
   localparam logic [W-1:0] MASK = '1;

   logic         clk = 1'b0;
   logic         rst;
   logic         op_valid;
   logic [W-1:0] reg_a, reg_b, imm;
   logic         use_imm, a_zero, cin_sel, ca_en, oe_en, rc_en;
   logic         res_valid;
   logic [W-1:0] result;
   logic         flag_ca, flag_ov, flag_so;
   logic [3:0]   cond;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // reference state
   logic         m_ca, m_ov, m_so;
   logic [W-1:0] m_res;
   logic [3:0]   m_cond;

   always #10 clk = ~clk;

   sum_flag_unit #(.DATA_W(W), .ADDER_STYLE(1)) i_sum_flag_unit (
      .clk(clk), .rst(rst), .op_valid(op_valid),
      .reg_a(reg_a), .reg_b(reg_b), .imm(imm),
      .use_imm(use_imm), .a_zero(a_zero), .cin_sel(cin_sel),
      .ca_en(ca_en), .oe_en(oe_en), .rc_en(rc_en),
      .res_valid(res_valid), .result(result),
      .flag_ca(flag_ca), .flag_ov(flag_ov), .flag_so(flag_so), .cond(cond)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string rres, input string rov, input string rcond,
                            input logic vexp);
      chk(rres, int'(result), int'(m_res));
      chk("R4", int'(flag_ca), int'(m_ca));
      chk(rov, int'(flag_ov), int'(m_ov));
      chk(rov, int'(flag_so), int'(m_so));
      chk(rcond, int'(cond), int'(m_cond));
      chk("R9", int'(res_valid), int'(vexp));
   endtask

   // drive at negedge, registered at posedge, checked at following negedge
   task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [5:0] ctl);
      logic [W-1:0] opa, opb, s;
      logic [W:0]   wide;
      logic         ci, ovf;
      string        rres, rov, rcond;
      op_valid = 1'b1;
      {use_imm, a_zero, cin_sel, ca_en, oe_en, rc_en} = ctl;
      reg_a = a;
      reg_b = use_imm ? ~b : b;
      imm   = use_imm ? b : ~b;
      opa   = a_zero ? '0 : a;
      opb   = b;
      ci    = cin_sel ? m_ca : 1'b0;
      wide  = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, ci};
      s     = wide[W-1:0];
      ovf   = (opa[W-1] == opb[W-1]) && (s[W-1] != opa[W-1]);
      m_res = s;
      if (ca_en) m_ca = wide[W];
      if (oe_en) begin
         m_ov = ovf;
         if (ovf) m_so = 1'b1;
      end
      if (rc_en) m_cond = {s[W-1], !s[W-1] && (s != 0), s == 0, m_so};
      rres  = a_zero ? "R3" : (cin_sel ? "R2" : "R1");
      rov   = (oe_en && ovf) ? "R5" : "R6";
      rcond = (oe_en && rc_en) ? "R8" : "R7";
      @(negedge clk);
      check_all(rres, rov, rcond, 1'b1);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      op_valid = 1'b1;   // must be ignored during reset
      @(negedge clk);
      rst = 1'b0;
      op_valid = 1'b0;
      m_ca = 0; m_ov = 0; m_so = 0; m_res = '0; m_cond = '0;
      check_all("R10", "R10", "R10", 1'b0);
   endtask

   initial begin
      rst = 1'b1; op_valid = 1'b0;
      reg_a = '0; reg_b = '0; imm = '0;
      {use_imm, a_zero, cin_sel, ca_en, oe_en, rc_en} = '0;
      @(negedge clk);
      @(negedge clk);
      do_reset();
      // R5/R8 directed: max positive + 1 with oe and rc
      run_op(4'h7, 4'h1, 6'b000011);
      chk("R8", int'(cond[0]), 1);
      // R6: later non-overflowing oe op clears ov, so stays
      run_op(4'h1, 4'h1, 6'b000010);
      chk("R6", int'(flag_so), 1);
      // R4/R2: carry out then consumed
      run_op(4'hF, 4'h1, 6'b000100);
      run_op(4'h2, 4'h3, 6'b001001);
      // R9: idle cycles hold everything
      op_valid = 1'b0;
      reg_a = 4'h5; reg_b = 4'h6;
      {use_imm, a_zero, cin_sel, ca_en, oe_en, rc_en} = 6'b111111;
      repeat (3) begin
         @(negedge clk);
         check_all("R9", "R9", "R9", 1'b0);
      end
      do_reset();
      // exhaustive sweep with chained state
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            for (int c = 0; c < 64; c++) begin
               run_op(W'(a), W'(b), 6'(c));
            end
         end
         if (a == 7) do_reset();
      end
      op_valid = 1'b0;
      @(negedge clk);
      check_all("R9", "R9", "R9", 1'b0);
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule